// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Retransmit

This block is a 36-bit FIFO whose write and read sides run on independent clocks. A read-timing mode is captured while master reset is held, and it fixes what the two status outputs mean:

- **Standard timing.** `flag_rd` reports empty and `flag_wr` reports full. A stored word reaches `dout` only after an explicit read.
- **Fall-through timing.** `flag_rd` reports that `dout` holds a valid word, and `flag_wr` reports that there is room to accept a write. The first word written into an empty FIFO is moved to `dout` without any read request. Each later word needs a read.

Two threshold flags compare the stored word count against offsets driven on input ports. Almost-empty is counted on the read side and almost-full on the write side.

The reset set has three actions:

- **Master reset** clears both pointers and reloads the timing mode.
- **Partial reset** clears both pointers and the output but keeps the timing mode.
- **Retransmit** rewinds only the read pointer to the first location, so everything written since the last reset can be replayed.

Partial reset and retransmit share one input. A mode input selects which action it performs.

Pointers cross between the clock domains in Gray code, with one bit more than the address. Each crossing passes through two register stages in the destination domain. A flag that depends on the other side's activity therefore changes a few clock cycles after that activity.

Top module: `dmfifo`

## Requirements
- R1: While `mrst` is high at a rising edge of both clocks, both pointers clear, `dout` becomes 0 and the timing mode is loaded from `fwft_sel` (0 = standard, 1 = fall-through). After reset in standard mode, `flag_rd`=1, `flag_wr`=0, `ae`=1 and `af`=0. In fall-through mode, `flag_rd`=0 and `flag_wr`=1.
- R2: In standard mode, `flag_rd` is 1 exactly when no word is stored and `flag_wr` is 1 exactly when DEPTH words are stored. A written word does not reach `dout` until a read. `dout` changes only on a rising `rclk` edge where `ren`=1 and the FIFO is not empty, and it shows the oldest word from that edge on.
- R3: In fall-through mode, the oldest word moves to `dout` without a read, and `flag_rd`=1 marks it valid. While `flag_rd`=1 and `ren`=0, `dout` holds. A read with `flag_rd`=1 consumes the word. `flag_wr`=0 once storage is full, which with the output word is DEPTH+1 words.
- R4: Words leave in the order they were written, including when a write and a read occur at the same time.
- R5: A write while storage is full is discarded: the write pointer does not move and the word is never read.
- R6: A read in standard mode while empty is ignored: the read pointer does not move, and the next word written is the next word read.
- R7: `ae`=1 when the stored count seen by the read side is at or below `ae_ofs`, else 0.
- R8: `af`=1 when the stored count seen by the write side exceeds DEPTH minus `af_ofs` (`af_ofs` from 0 to DEPTH), else 0.
- R9: `prst_rt`=1 with `rt_mode`=0 at rising edges of both clocks empties the FIFO and clears `dout`. It keeps the timing mode captured at master reset.
- R10: `prst_rt`=1 with `rt_mode`=1 at a rising `rclk` edge returns the read pointer to the first location. The write pointer is left alone, so the words written since the last reset are read again in order, followed by any new words. It is valid while fewer than DEPTH words have been written since the last reset.
- R11: Write-side flags see read progress, and read-side flags see write progress, only through two register stages of their own clock. `flag_rd` still shows empty at the first falling `wclk` edge after the write into an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous, active high, sampled by both clocks |
| prst_rt | input | 1 | Partial reset or retransmit request, selected by `rt_mode` |
| rt_mode | input | 1 | 0: `prst_rt` is a partial reset; 1: `prst_rt` is a retransmit |
| fwft_sel | input | 1 | Timing mode captured during master reset |
| wen | input | 1 | Write enable |
| din | input | 36 | Write data |
| ren | input | 1 | Read enable |
| ae_ofs | input | AW+1 | Almost-empty offset |
| af_ofs | input | AW+1 | Almost-full offset |
| dout | output | 36 | Read data |
| flag_wr | output | 1 | Full (standard) or input-ready (fall-through) |
| flag_rd | output | 1 | Empty (standard) or output-ready (fall-through) |
| ae | output | 1 | Almost-empty |
| af | output | 1 | Almost-full |

## Verification
The checker watches, on every cycle:
- that a write or read against a full or empty FIFO leaves its pointer still;
- that the crossing write pointer changes by at most one Gray bit per edge;
- that full implies almost-full;
- that the mode register moves only under master reset;
- that `dout` holds between reads in both modes.

Only the bench scenarios can show:
- end-to-end word order across the clock crossing;
- where the threshold flags switch;
- the replay after retransmit;
- that partial reset keeps fall-through meanings;
- that the empty flag lags a write by its synchroniser stages.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    localparam int DATA_W = 36;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } mode_t;

    typedef struct packed {
        logic master;
        logic flush;
        logic rewind;
    } rst_cmd_t;

    function automatic rst_cmd_t decode_rst(input logic mrst, input logic prst_rt,
                                            input logic rt_mode);
        rst_cmd_t c;
        c.master = mrst;
        c.flush  = !mrst && prst_rt && !rt_mode;
        c.rewind = !mrst && prst_rt && rt_mode;
        return c;
    endfunction

endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (clr) begin
                stage1[i] <= 1'b0;
                q[i]      <= 1'b0;
            end else begin
                stage1[i] <= d[i];
                q[i]      <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/dmf_wside.sv
module dmf_wside
    import dmf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        master,
    input  logic        flush,
    input  logic        mode_sel,
    input  logic        wen,
    input  logic [AW:0] rgray_s,
    input  logic [AW:0] af_ofs,
    output logic [AW:0] wbin,
    output logic [AW:0] wgray,
    output logic        push,
    output logic        full,
    output logic        afull,
    output mode_t       mode
);
    localparam logic [AW+1:0] DEPTH_X = {2'b01, {AW{1'b0}}};

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [AW:0] wnext, rbin_s, fill;

    always_comb begin
        full   = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
        push   = wen && !full;
        wnext  = wbin + 1'b1;
        rbin_s = g2b(rgray_s);
        fill   = wbin - rbin_s;
        afull  = {1'b0, fill} > (DEPTH_X - {1'b0, af_ofs});
    end

    always_ff @(posedge clk) begin
        if (master) begin
            wbin  <= '0;
            wgray <= '0;
            mode  <= mode_t'(mode_sel);
        end else if (flush) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push) begin
            wbin  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end
endmodule

// File: rtl/dmf_rside.sv
module dmf_rside
    import dmf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  rst_cmd_t      cmd,
    input  logic          mode_sel,
    input  logic          ren,
    input  logic [AW:0]   wgray_s,
    input  logic [AW:0]   ae_ofs,
    input  word_t         rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output word_t         dout,
    output logic          dvalid,
    output logic          mem_empty,
    output logic          aempty,
    output mode_t         mode
);
    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [AW:0] rnext, level;
    logic        take;

    always_comb begin
        mem_empty = (rgray == wgray_s);
        level     = g2b(wgray_s) - rbin;
        aempty    = level <= ae_ofs;
        rnext     = rbin + 1'b1;
        raddr     = rbin[AW-1:0];
        if (mode == MODE_FWFT) take = !mem_empty && (!dvalid || ren);
        else                   take = ren && !mem_empty;
    end

    always_ff @(posedge clk) begin
        if (cmd.master || cmd.flush) begin
            rbin   <= '0;
            rgray  <= '0;
            dout   <= '0;
            dvalid <= 1'b0;
            if (cmd.master) mode <= mode_t'(mode_sel);
        end else if (cmd.rewind) begin
            rbin   <= '0;
            rgray  <= '0;
            dvalid <= 1'b0;
        end else if (take) begin
            rbin   <= rnext;
            rgray  <= rnext ^ (rnext >> 1);
            dout   <= rdata;
            dvalid <= (mode == MODE_FWFT);
        end else if (ren) begin
            dvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/dmfifo.sv
module dmfifo
    import dmf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                           wclk,
    input  logic                           rclk,
    input  logic                           mrst,
    input  logic                           prst_rt,
    input  logic                           rt_mode,
    input  logic                           fwft_sel,
    input  logic                           wen,
    input  logic [dmf_pkg::DATA_W-1:0]     din,
    input  logic                           ren,
    input  logic [AW:0]                    ae_ofs,
    input  logic [AW:0]                    af_ofs,
    output logic [dmf_pkg::DATA_W-1:0]     dout,
    output logic                           flag_wr,
    output logic                           flag_rd,
    output logic                           ae,
    output logic                           af
);
    localparam int DEPTH = 1 << AW;

    rst_cmd_t      cmd;
    logic [AW:0]   w_bin, w_gray, r_bin, r_gray, wgray_s, rgray_s;
    logic [AW-1:0] r_addr;
    logic          w_push, w_full, r_empty, r_dvalid;
    mode_t         w_mode, r_mode;
    word_t         mem [DEPTH];

    assign cmd = decode_rst(mrst, prst_rt, rt_mode);

    always_ff @(posedge wclk) begin
        if (w_push) mem[w_bin[AW-1:0]] <= din;
    end

    dmf_sync #(.W(AW + 1)) i_w2r (
        .clk(rclk), .clr(cmd.master || cmd.flush), .d(w_gray), .q(wgray_s)
    );

    dmf_sync #(.W(AW + 1)) i_r2w (
        .clk(wclk), .clr(cmd.master || cmd.flush), .d(r_gray), .q(rgray_s)
    );

    dmf_wside #(.AW(AW)) i_wside (
        .clk(wclk), .master(cmd.master), .flush(cmd.flush), .mode_sel(fwft_sel),
        .wen(wen), .rgray_s(rgray_s), .af_ofs(af_ofs), .wbin(w_bin), .wgray(w_gray),
        .push(w_push), .full(w_full), .afull(af), .mode(w_mode)
    );

    dmf_rside #(.AW(AW)) i_rside (
        .clk(rclk), .cmd(cmd), .mode_sel(fwft_sel), .ren(ren), .wgray_s(wgray_s),
        .ae_ofs(ae_ofs), .rdata(mem[r_addr]), .raddr(r_addr), .rbin(r_bin),
        .rgray(r_gray), .dout(dout), .dvalid(r_dvalid), .mem_empty(r_empty),
        .aempty(ae), .mode(r_mode)
    );

    assign flag_wr = (w_mode == MODE_FWFT) ? !w_full : w_full;
    assign flag_rd = (r_mode == MODE_FWFT) ? r_dvalid : r_empty;
endmodule

// File: rtl/dmfifo_chk.sv
module dmfifo_chk #(
    parameter int AW = 4
) (
    input logic        wclk,
    input logic        rclk,
    input logic        mrst,
    input logic        prst_rt,
    input logic        rt_mode,
    input logic        wen,
    input logic        ren,
    input logic        w_full,
    input logic        r_empty,
    input logic [AW:0] w_bin,
    input logic [AW:0] w_gray,
    input logic [AW:0] r_bin,
    input logic        fwft_w,
    input logic        fwft_r,
    input logic        dvalid,
    input logic [35:0] dout,
    input logic        af,
    input logic [AW:0] af_ofs
);
    logic w_rst, r_rst;
    logic w_rst_d = 1'b1;

    assign w_rst = mrst || (prst_rt && !rt_mode);
    assign r_rst = mrst || prst_rt;

    always @(posedge wclk) w_rst_d <= w_rst;

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (w_rst)
        (w_full && wen) |=> $stable(w_bin)); // R5

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (r_rst)
        (r_empty && ren && !fwft_r) |=> $stable(r_bin)); // R6

    AST_GRAY_STEP: assert property (@(posedge wclk) disable iff (w_rst || w_rst_d)
        $countones(w_gray ^ $past(w_gray)) <= 1); // R11

    AST_FULL_IMPLIES_AF: assert property (@(posedge wclk) disable iff (w_rst)
        (w_full && af_ofs != '0) |-> af); // R8

    AST_MODE_KEPT: assert property (@(posedge wclk) disable iff (mrst)
        1'b1 |=> $stable(fwft_w)); // R9

    AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (r_rst)
        (fwft_r && dvalid && !ren) |=> (dvalid && $stable(dout))); // R3

    AST_STD_HOLD: assert property (@(posedge rclk) disable iff (r_rst)
        (!fwft_r && !ren) |=> $stable(dout)); // R2
endmodule

bind dmfifo dmfifo_chk #(.AW(AW)) i_chk (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst_rt(prst_rt), .rt_mode(rt_mode),
    .wen(wen), .ren(ren), .w_full(w_full), .r_empty(r_empty), .w_bin(w_bin),
    .w_gray(w_gray), .r_bin(r_bin), .fwft_w(w_mode), .fwft_r(r_mode),
    .dvalid(r_dvalid), .dout(dout), .af(af), .af_ofs(af_ofs)
);

// File: tb/test_dmfifo.sv
module test_dmfifo;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic        wclk = 1'b0, rclk = 1'b0;
    logic        mrst = 1'b1, prst_rt = 1'b0, rt_mode = 1'b0, fwft_sel = 1'b0;
    logic        wen = 1'b0, ren = 1'b0;
    logic [35:0] din = '0;
    logic [AW:0] ae_ofs = 5'd3, af_ofs = 5'd4;
    logic [35:0] dout;
    logic        flag_wr, flag_rd, ae, af;

    int vectors = 0, errors = 0;
    bit done = 1'b0;
    logic [35:0] exp_q[$];

    dmfifo #(.AW(AW)) i_dmfifo (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst_rt(prst_rt), .rt_mode(rt_mode),
        .fwft_sel(fwft_sel), .wen(wen), .din(din), .ren(ren), .ae_ofs(ae_ofs),
        .af_ofs(af_ofs), .dout(dout), .flag_wr(flag_wr), .flag_rd(flag_rd),
        .ae(ae), .af(af)
    );

    always #10 wclk = ~wclk;
    initial begin
        #3;
        forever #10 rclk = ~rclk;
    end

    task automatic chk(input bit ok, input string tag, input logic [35:0] act,
                       input logic [35:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge wclk);
    endtask

    // driver: one write; the expected word is queued only if it should be accepted
    task automatic wr(input logic [35:0] d, input bit accept);
        @(negedge wclk);
        wen = 1'b1;
        din = d;
        if (accept) exp_q.push_back(d);
        @(negedge wclk);
        wen = 1'b0;
    endtask

    // monitor, standard mode: issue a read, compare the word that appears
    task automatic rd_std(input string tag);
        logic [35:0] e;
        @(negedge rclk);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 36'hBAD;
        chk(dout == e, tag, dout, e);
    endtask

    // monitor, fall-through mode: compare the presented word, then consume it
    task automatic rd_fwft(input string tag);
        logic [35:0] e;
        @(negedge rclk);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 36'hBAD;
        chk(flag_rd == 1'b1, tag, {35'd0, flag_rd}, 36'd1);
        chk(dout == e, tag, dout, e);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
    endtask

    task automatic master_reset(input logic mode);
        @(negedge wclk);
        mrst = 1'b1;
        fwft_sel = mode;
        wt(3);
        mrst = 1'b0;
        exp_q.delete();
        wt(2);
    endtask

    task automatic partial_reset();
        @(negedge wclk);
        prst_rt = 1'b1;
        rt_mode = 1'b0;
        wt(3);
        prst_rt = 1'b0;
        exp_q.delete();
        wt(4);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        master_reset(1'b0);
        // R1 reset state in standard mode
        chk(flag_rd == 1'b1, "R1 empty after reset", {35'd0, flag_rd}, 36'd1);
        chk(flag_wr == 1'b0, "R1 full after reset", {35'd0, flag_wr}, 36'd0);
        chk(ae == 1'b1, "R1 ae after reset", {35'd0, ae}, 36'd1);
        chk(af == 1'b0, "R1 af after reset", {35'd0, af}, 36'd0);
        chk(dout == 36'd0, "R1 dout after reset", dout, 36'd0);

        wr(36'hA_0000_0001, 1'b1);
        // R11 the empty flag has not yet seen the write
        chk(flag_rd == 1'b1, "R11 empty lags write", {35'd0, flag_rd}, 36'd1);
        wr(36'hA_0000_0002, 1'b1);
        wr(36'hA_0000_0003, 1'b1);
        wt(6);
        chk(flag_rd == 1'b0, "R2 not empty", {35'd0, flag_rd}, 36'd0);
        chk(dout == 36'd0, "R2 no fall-through", dout, 36'd0);
        chk(ae == 1'b1, "R7 ae at count 3", {35'd0, ae}, 36'd1);
        wr(36'hA_0000_0004, 1'b1);
        wt(6);
        chk(ae == 1'b0, "R7 ae at count 4", {35'd0, ae}, 36'd0);

        for (int i = 5; i <= 12; i++) wr(36'hB_0000_0000 + 36'(i), 1'b1);
        chk(af == 1'b0, "R8 af at count 12", {35'd0, af}, 36'd0);
        wr(36'hB_0000_000D, 1'b1);
        chk(af == 1'b1, "R8 af at count 13", {35'd0, af}, 36'd1);
        for (int i = 14; i <= DEPTH; i++) wr(36'hB_0000_0000 + 36'(i), 1'b1);
        chk(flag_wr == 1'b1, "R2 full at DEPTH", {35'd0, flag_wr}, 36'd1);
        wr(36'hDEAD_BEEF, 1'b0);
        chk(flag_wr == 1'b1, "R5 still full", {35'd0, flag_wr}, 36'd1);

        for (int i = 0; i < DEPTH; i++) rd_std("R4 R5 drain order");
        wt(2);
        chk(flag_rd == 1'b1, "R2 empty after drain", {35'd0, flag_rd}, 36'd1);

        // R6 read while empty, then one write and read
        @(negedge rclk);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
        chk(dout == 36'hB_0000_0010, "R6 dout unchanged by empty read", dout, 36'hB_0000_0010);
        wr(36'hC_0000_0001, 1'b1);
        wt(6);
        rd_std("R6 next word after empty read");

        // R4 concurrent write and read
        wr(36'hC_0000_0002, 1'b1);
        wr(36'hC_0000_0003, 1'b1);
        wt(6);
        fork
            wr(36'hC_0000_0004, 1'b1);
            rd_std("R4 concurrent read");
        join
        wt(6);
        rd_std("R4 after concurrent");
        rd_std("R4 after concurrent");

        // R10 retransmit
        partial_reset();
        chk(flag_rd == 1'b1, "R9 empty after partial reset", {35'd0, flag_rd}, 36'd1);
        for (int i = 0; i < 4; i++) wr(36'hD_0000_0000 + 36'(i), 1'b1);
        wt(6);
        for (int i = 0; i < 4; i++) rd_std("R10 first pass");
        wt(2);
        chk(flag_rd == 1'b1, "R10 empty before rewind", {35'd0, flag_rd}, 36'd1);
        @(negedge rclk);
        prst_rt = 1'b1;
        rt_mode = 1'b1;
        @(negedge rclk);
        prst_rt = 1'b0;
        rt_mode = 1'b0;
        wt(6);
        chk(flag_rd == 1'b0, "R10 data after rewind", {35'd0, flag_rd}, 36'd0);
        for (int i = 0; i < 4; i++) exp_q.push_back(36'hD_0000_0000 + 36'(i));
        for (int i = 0; i < 4; i++) rd_std("R10 replay");
        wr(36'hD_0000_00EE, 1'b1);
        wt(6);
        rd_std("R10 write pointer kept");

        // R3 fall-through mode
        master_reset(1'b1);
        chk(flag_rd == 1'b0, "R1 fwft output-ready after reset", {35'd0, flag_rd}, 36'd0);
        chk(flag_wr == 1'b1, "R1 fwft input-ready after reset", {35'd0, flag_wr}, 36'd1);
        wr(36'hE_0000_0001, 1'b1);
        chk(flag_rd == 1'b0, "R11 output-ready lags write", {35'd0, flag_rd}, 36'd0);
        wt(6);
        chk(flag_rd == 1'b1, "R3 first word ready", {35'd0, flag_rd}, 36'd1);
        chk(dout == 36'hE_0000_0001, "R3 first word falls through", dout, 36'hE_0000_0001);

        partial_reset();
        chk(flag_rd == 1'b0, "R9 fwft kept, output-ready", {35'd0, flag_rd}, 36'd0);
        chk(flag_wr == 1'b1, "R9 fwft kept, input-ready", {35'd0, flag_wr}, 36'd1);
        chk(dout == 36'd0, "R9 dout cleared", dout, 36'd0);

        for (int i = 0; i <= DEPTH; i++) begin
            wr(36'hF_0000_0000 + 36'(i), 1'b1);
            wt(1);
        end
        wt(6);
        chk(flag_wr == 1'b0, "R3 input-ready low at DEPTH+1", {35'd0, flag_wr}, 36'd0);
        for (int i = 0; i <= DEPTH; i++) begin
            rd_fwft("R3 R4 fwft drain");
            if (i < DEPTH) wt(4);
        end
        wt(6);
        chk(flag_rd == 1'b0, "R3 output-ready low after drain", {35'd0, flag_rd}, 36'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule